// File: doc/BRIEF.md
# Parallel NOR Flash Command Sequencer

This block sits between a host-side request port and an asynchronous parallel NOR flash with a 16-bit data path. The host asks for one of four operations: read the identification and sector lock state, program a single word, erase an inclusive span of sectors, or put the flash back into array-read mode. The sequencer expands each request into the flash's unlock writes and command writes. It then polls the flash's completion bit until the operation ends or a cycle budget runs out, and reports a two-bit result code.

The flash side uses a simple strobe handshake. The block raises a write or read strobe with a stable address, and stable data for a write. It holds all of them until the attachment returns a one-cycle acknowledge. Read data must be valid while that acknowledge is high. The sector lock flags gathered by the last identify decide which sectors an erase leaves alone. When the flash is wired with its two byte lanes reversed, a mode input exchanges the bytes of every word crossing the pins, so the host and the internal logic always see words in natural order.

Sector size, sector count, unlock addresses, both timeouts and the settle delay after an erase are parameters counted in words and clock cycles.

Top module: `nor_cmd_seq`

## Requirements
- R1: While reset is held and right after it, req_ready is 1, done is 0, status is 0 and neither fl_we nor fl_re is active.
- R2: A raised strobe keeps its address, and for a write its data, unchanged until fl_ack is seen; fl_we and fl_re are never active together.
- R3: Identify (req_op 0) writes 0x00AA to UNLK1, 0x0055 to UNLK2 and 0x0090 to UNLK1. It reads word 0 into id_mfr and word 1 into id_dev. It then reads word offset 2 of every sector base in ascending order, and bit 0 of that word becomes prot_flags[sector]. Finally it writes 0x00F0 to address 0.
- R4: Program (req_op 1) writes the unlock pair, 0x00A0 to UNLK1, then req_data to req_addr. It polls req_addr until bit 7 read back equals bit 7 of req_data, then finishes with status 0. The flash is left holding the new word.
- R5: Before any write, program reads req_addr. If (contents AND req_data) differs from req_data, it finishes with status 2 and issues no write cycle.
- R6: If a program poll is still unfinished once PROG_TMO cycles have passed in polling, the request ends with status 1.
- R7: Erase (req_op 2) visits sectors req_first through req_last in ascending order. For each unlocked sector it writes the unlock pair, 0x0080 to UNLK1, the unlock pair again and 0x0030 to the sector base. It polls the sector base until bit 7 reads 1 and only then moves on.
- R8: A sector whose prot_flags bit is set receives no command and keeps its contents. skip_cnt reports how many such sectors the last erase passed over.
- R9: After the last sector of an erase, at least SETTLE_CYC cycles elapse after the last poll read before 0x00F0 is written to address 0.
- R10: If an erase poll is still unfinished once ERASE_TMO cycles have passed, the remaining sectors are abandoned. The status is 1, and the settle wait and the 0x00F0 write still take place.
- R11: An erase with req_first greater than req_last ends with status 0 and makes no bus access.
- R12: Reset-to-read (req_op 3) makes exactly one write, 0x00F0 to address 0, and ends with status 0.
- R13: With swap_bytes at 1, bits [15:8] and [7:0] are exchanged on every word written to fl_wdata and every word taken from fl_rdata. Identification, lock flags, program data and the erased check are all unchanged as seen from the request port.
- R14: A request is taken when req_valid and req_ready are both 1, and req_ready stays 0 until completion. done is a single-cycle pulse with status valid in the same cycle, and req_ready returns in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| swap_bytes | input | 1 | Exchange byte lanes at the flash pins |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | 0 identify, 1 program, 2 erase range, 3 reset to read |
| req_addr | input | AW | Word address for program |
| req_data | input | 16 | Word to program |
| req_first | input | SW | First sector of erase range |
| req_last | input | SW | Last sector of erase range |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 OK, 1 timeout, 2 not erased |
| id_mfr | output | 16 | Manufacturer word from last identify |
| id_dev | output | 16 | Device word from last identify |
| prot_flags | output | 2**SW | Per-sector lock flags from last identify |
| skip_cnt | output | SW+1 | Locked sectors skipped by last erase |
| fl_addr | output | AW | Flash word address |
| fl_wdata | output | 16 | Flash write data |
| fl_rdata | input | 16 | Flash read data |
| fl_we | output | 1 | Write strobe |
| fl_re | output | 1 | Read strobe |
| fl_ack | input | 1 | Access acknowledge |

## Verification
The bench sets up a word that only clears bits against one that would need a bit set again. A sequencer that got the erased test wrong would either refuse a legal overwrite or, worse, write into a dirty word. The write counter shows that no cycle reaches the flash on a refusal. Erase spans mix locked and unlocked sectors: a wrong lock lookup would wipe the planted words in locked sectors, and a wrong walk would log sectors out of order or miss them. A flash model that never finishes drives both timeouts, where a broken budget hangs the request or an erase timeout fails to abandon the span and skip straight to the settle and reset. The settle gap before the final reset write is measured in cycles, and byte-lane swapping is exercised with identify and program, where a missing swap on either direction corrupts the unlock codes or the words read back.

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq #(
  parameter int AW = 20,
  parameter int SW = 3,
  parameter int SECT_SHIFT = 16,
  parameter logic [AW-1:0] UNLK1 = 'h555,
  parameter logic [AW-1:0] UNLK2 = 'h2AA,
  parameter int PROG_TMO = 2000,
  parameter int ERASE_TMO = 200000,
  parameter int SETTLE_CYC = 8000
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 swap_bytes,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_op,
  input  logic [AW-1:0]        req_addr,
  input  logic [15:0]          req_data,
  input  logic [SW-1:0]        req_first,
  input  logic [SW-1:0]        req_last,
  output logic                 done,
  output logic [1:0]           status,
  output logic [15:0]          id_mfr,
  output logic [15:0]          id_dev,
  output logic [(1<<SW)-1:0]   prot_flags,
  output logic [SW:0]          skip_cnt,
  output logic [AW-1:0]        fl_addr,
  output logic [15:0]          fl_wdata,
  input  logic [15:0]          fl_rdata,
  output logic                 fl_we,
  output logic                 fl_re,
  input  logic                 fl_ack
);
  localparam int NSECT = 1 << SW;
  localparam logic [1:0] OP_ID = 2'd0, OP_PROG = 2'd1, OP_ERASE = 2'd2, OP_RST = 2'd3;

  typedef enum logic [3:0] {
    S_IDLE, S_PRE, S_SEQ, S_POLL, S_NEXT, S_IDRD, S_SETTLE, S_RST, S_DONE
  } st_t;

  function automatic logic [AW-1:0] sbase(input logic [SW-1:0] s);
    logic [AW-1:0] b;
    b = '0;
    b[SECT_SHIFT +: SW] = s;
    return b;
  endfunction

  st_t             st;
  logic [1:0]      op;
  logic [AW-1:0]   tgt;
  logic [15:0]     wdat;
  logic [SW-1:0]   sec, slast;
  logic [2:0]      stp;
  logic [31:0]     cnt;
  logic            we_q, re_q;
  logic [AW-1:0]   a_q;
  logic [15:0]     d_q;
  logic [1:0]      rstat;
  logic [15:0]     mfr_q, dev_q;
  logic [NSECT-1:0] prot_q;
  logic [SW:0]     skip_q;

  logic [15:0]     rdl;
  logic            ack_w, ack_r;
  logic [AW-1:0]   s_addr, poll_addr, id_addr, l_addr;
  logic [15:0]     s_data, l_data;
  logic            seq_end, poll_ok, l_go, l_we;
  logic [31:0]     tmo_lim;

  assign rdl   = swap_bytes ? {fl_rdata[7:0], fl_rdata[15:8]} : fl_rdata;
  assign ack_w = we_q & fl_ack;
  assign ack_r = re_q & fl_ack;

  always_comb begin
    s_addr = UNLK1;
    s_data = 16'h00AA;
    case (stp)
      3'd0: ;
      3'd1: begin s_addr = UNLK2; s_data = 16'h0055; end
      3'd2: s_data = (op == OP_PROG) ? 16'h00A0 : (op == OP_ERASE) ? 16'h0080 : 16'h0090;
      3'd3: if (op == OP_PROG) begin s_addr = tgt; s_data = wdat; end
      3'd4: begin s_addr = UNLK2; s_data = 16'h0055; end
      default: begin s_addr = sbase(sec); s_data = 16'h0030; end
    endcase
  end

  assign seq_end   = (op == OP_PROG) ? (stp == 3'd3) : (op == OP_ERASE) ? (stp == 3'd5) : (stp == 3'd2);
  assign poll_addr = (op == OP_PROG) ? tgt : sbase(sec);
  assign poll_ok   = (op == OP_PROG) ? (rdl[7] == wdat[7]) : rdl[7];
  assign tmo_lim   = (op == OP_PROG) ? 32'(PROG_TMO) : 32'(ERASE_TMO);
  assign id_addr   = (stp == 3'd0) ? '0 : (stp == 3'd1) ? AW'(1) : (sbase(sec) | AW'(2));

  assign l_go = (st == S_PRE) || (st == S_SEQ) || (st == S_POLL) || (st == S_IDRD) || (st == S_RST);
  assign l_we = (st == S_SEQ) || (st == S_RST);

  always_comb begin
    case (st)
      S_SEQ:          l_addr = s_addr;
      S_PRE, S_POLL:  l_addr = poll_addr;
      S_IDRD:         l_addr = id_addr;
      default:        l_addr = '0;
    endcase
    case (st)
      S_SEQ:   l_data = s_data;
      S_RST:   l_data = 16'h00F0;
      default: l_data = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; op <= OP_ID; tgt <= '0; wdat <= '0;
      sec <= '0; slast <= '0; stp <= '0; cnt <= '0;
      we_q <= 1'b0; re_q <= 1'b0; a_q <= '0; d_q <= '0;
      rstat <= 2'd0; mfr_q <= '0; dev_q <= '0; prot_q <= '0; skip_q <= '0;
    end else begin
      if (we_q || re_q) begin
        if (fl_ack) begin
          we_q <= 1'b0;
          re_q <= 1'b0;
        end
      end else if (l_go) begin
        we_q <= l_we;
        re_q <= !l_we;
        a_q  <= l_addr;
        d_q  <= l_data;
      end

      case (st)
        S_IDLE: if (req_valid) begin
          op    <= req_op;
          tgt   <= req_addr;
          wdat  <= req_data;
          rstat <= 2'd0;
          stp   <= '0;
          case (req_op)
            OP_ID:   st <= S_SEQ;
            OP_PROG: st <= S_PRE;
            OP_ERASE: begin
              skip_q <= '0;
              if (req_first > req_last) st <= S_DONE;
              else begin
                sec   <= req_first;
                slast <= req_last;
                st    <= S_NEXT;
              end
            end
            default: st <= S_RST;
          endcase
        end
        S_PRE: if (ack_r) begin
          if ((rdl & wdat) != wdat) begin
            rstat <= 2'd2;
            st    <= S_DONE;
          end else begin
            stp <= '0;
            st  <= S_SEQ;
          end
        end
        S_SEQ: if (ack_w) begin
          if (seq_end) begin
            stp <= '0;
            cnt <= '0;
            if (op == OP_ID) begin
              sec <= '0;
              st  <= S_IDRD;
            end else st <= S_POLL;
          end else stp <= stp + 3'd1;
        end
        S_POLL: begin
          cnt <= cnt + 32'd1;
          if (ack_r) begin
            if (poll_ok) begin
              if (op == OP_PROG) st <= S_DONE;
              else if (sec == slast) begin
                cnt <= '0;
                st  <= S_SETTLE;
              end else begin
                sec <= sec + 1'b1;
                st  <= S_NEXT;
              end
            end else if (cnt >= tmo_lim) begin
              rstat <= 2'd1;
              cnt   <= '0;
              st    <= (op == OP_PROG) ? S_DONE : S_SETTLE;
            end
          end
        end
        S_NEXT: begin
          if (prot_q[sec]) begin
            skip_q <= skip_q + 1'b1;
            if (sec == slast) begin
              cnt <= '0;
              st  <= S_SETTLE;
            end else sec <= sec + 1'b1;
          end else begin
            stp <= '0;
            st  <= S_SEQ;
          end
        end
        S_IDRD: if (ack_r) begin
          case (stp)
            3'd0: begin mfr_q <= rdl; stp <= 3'd1; end
            3'd1: begin dev_q <= rdl; stp <= 3'd2; end
            default: begin
              prot_q[sec] <= rdl[0];
              if (&sec) st <= S_RST;
              else sec <= sec + 1'b1;
            end
          endcase
        end
        S_SETTLE: begin
          if (cnt >= 32'(SETTLE_CYC)) st <= S_RST;
          else cnt <= cnt + 32'd1;
        end
        S_RST:  if (ack_w) st <= S_DONE;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign req_ready  = (st == S_IDLE);
  assign done       = (st == S_DONE);
  assign status     = rstat;
  assign id_mfr     = mfr_q;
  assign id_dev     = dev_q;
  assign prot_flags = prot_q;
  assign skip_cnt   = skip_q;
  assign fl_addr    = a_q;
  assign fl_we      = we_q;
  assign fl_re      = re_q;
  assign fl_wdata   = swap_bytes ? {d_q[7:0], d_q[15:8]} : d_q;
endmodule

// File: rtl/nor_cmd_seq_chk.sv
module nor_cmd_seq_chk #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic [1:0]    status,
  input logic          fl_we,
  input logic          fl_re,
  input logic          fl_ack,
  input logic [AW-1:0] fl_addr,
  input logic [15:0]   fl_wdata
);
  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(fl_we && fl_re));
  // R2
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_we && !fl_ack) |=> (fl_we && $stable(fl_addr) && $stable(fl_wdata)));
  // R2
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fl_re && !fl_ack) |=> (fl_re && $stable(fl_addr)));
  // R14
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R14
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !req_ready);
  // R14
  ready_back_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> req_ready);
  // R14
  accept_chk: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> !req_ready);
  // R4
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (status != 2'd3));
endmodule

bind nor_cmd_seq nor_cmd_seq_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .status(status), .fl_we(fl_we), .fl_re(fl_re), .fl_ack(fl_ack),
  .fl_addr(fl_addr), .fl_wdata(fl_wdata)
);

// File: tb/nor_cmd_seq_tb.sv
`timescale 1ns/100ps
module nor_cmd_seq_tb;
  localparam int AW = 11, SW = 2, SHIFT = 9;
  localparam int SETTLE = 16;

  logic clk = 1'b0, rst_n = 1'b0, swp = 1'b0;
  logic req_valid = 1'b0, req_ready;
  logic [1:0] req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic [SW-1:0] req_first = '0, req_last = '0;
  logic done;
  logic [1:0] status;
  logic [15:0] id_mfr, id_dev;
  logic [3:0] prot_flags;
  logic [SW:0] skip_cnt;
  logic [AW-1:0] fl_addr;
  logic [15:0] fl_wdata;
  logic [15:0] fl_rdata = '0;
  logic fl_we, fl_re;
  logic fl_ack = 1'b0;

  always #2.5 clk = ~clk;

  nor_cmd_seq #(.AW(AW), .SW(SW), .SECT_SHIFT(SHIFT), .UNLK1(11'h555), .UNLK2(11'h2AA),
    .PROG_TMO(40), .ERASE_TMO(60), .SETTLE_CYC(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .swap_bytes(swp), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_data(req_data), .req_first(req_first),
    .req_last(req_last), .done(done), .status(status), .id_mfr(id_mfr), .id_dev(id_dev),
    .prot_flags(prot_flags), .skip_cnt(skip_cnt), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
    .fl_rdata(fl_rdata), .fl_we(fl_we), .fl_re(fl_re), .fl_ack(fl_ack));

  // behavioural flash model, logical words; pins may be byte-swapped
  logic [15:0] mem [0:2047];
  logic [3:0] lockm = 4'b1010;
  int cc = 0, md = 0, bl = 0, n_wr = 0, n_rd = 0, n_f0 = 0, cyc = 0;
  int rd_cyc = 0, f0_cyc = 0, er_n = 0, hs_bad = 0;
  int er_log [4];
  bit fin7 = 1'b0, stuck = 1'b0, pend = 1'b0, pwe = 1'b0, pre = 1'b0;
  logic [AW-1:0] paddr = '0;

  function automatic logic [15:0] bsw(input logic [15:0] v, input bit s);
    return s ? {v[7:0], v[15:8]} : v;
  endfunction

  always @(posedge clk) begin
    logic [15:0] lw, lr;
    logic [AW-1:0] a;
    cyc++;
    if (pend && ((fl_we != pwe) || (fl_re != pre) || (fl_addr != paddr))) hs_bad++;
    pend = (fl_we || fl_re) && !fl_ack;
    pwe = fl_we; pre = fl_re; paddr = fl_addr;
    if ((fl_we || fl_re) && !fl_ack) begin
      a = fl_addr;
      lw = bsw(fl_wdata, swp);
      lr = 16'h0000;
      if (fl_we) begin
        n_wr++;
        if (lw == 16'h00F0) begin
          md = 0; cc = 0; n_f0++; f0_cyc = cyc;
        end else if (md == 2) begin
        end else begin
          case (cc)
            0: cc = (a == 11'h555 && lw == 16'h00AA) ? 1 : 0;
            1: cc = (a == 11'h2AA && lw == 16'h0055) ? 2 : 0;
            2: begin
              cc = 0;
              if (a == 11'h555 && lw == 16'h0090) md = 1;
              else if (a == 11'h555 && lw == 16'h00A0) cc = 10;
              else if (a == 11'h555 && lw == 16'h0080) cc = 3;
            end
            3: cc = (a == 11'h555 && lw == 16'h00AA) ? 4 : 0;
            4: cc = (a == 11'h2AA && lw == 16'h0055) ? 5 : 0;
            5: begin
              cc = 0;
              if (lw == 16'h0030 && !lockm[a[10:9]]) begin
                for (int k = 0; k < 512; k++) mem[{a[10:9], 9'(k)}] = 16'hFFFF;
                if (er_n < 4) er_log[er_n] = int'(a[10:9]);
                er_n++;
                md = 2; bl = 3; fin7 = 1'b1;
              end
            end
            10: begin
              cc = 0;
              mem[a] = mem[a] & lw;
              md = 2; bl = 3; fin7 = lw[7];
            end
            default: cc = 0;
          endcase
        end
      end else begin
        n_rd++; rd_cyc = cyc;
        if (md == 2) begin
          if (stuck || bl > 0) begin
            bl--;
            lr = {8'h00, ~fin7, 7'h00};
          end else begin
            md = 0;
            lr = mem[a];
          end
        end else if (md == 1) begin
          case (a[8:0])
            9'd0: lr = 16'h0001;
            9'd1: lr = 16'h22F9;
            9'd2: lr = {15'h0000, lockm[a[10:9]]};
            default: lr = 16'h0000;
          endcase
        end else lr = mem[a];
      end
      fl_rdata <= bsw(lr, swp);
      fl_ack <= 1'b1;
    end else fl_ack <= 1'b0;
  end

  int total = 0, bad = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] op, input logic [AW-1:0] a, input logic [15:0] d,
                     input logic [SW-1:0] f, input logic [SW-1:0] l, output logic [1:0] st);
    @(negedge clk);
    req_op = op; req_addr = a; req_data = d; req_first = f; req_last = l;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (!done) @(negedge clk);
    st = status;
  endtask

  typedef struct packed {
    logic [1:0] op; logic [10:0] a; logic [15:0] d; logic [1:0] f; logic [1:0] l;
    logic [1:0] st; logic [10:0] ca; logic [15:0] cv;
  } vec_t;

  localparam vec_t VEC [9] = '{
    '{2'd1, 11'h010, 16'h1234, 2'd0, 2'd0, 2'd0, 11'h010, 16'h1234},  // R4
    '{2'd1, 11'h010, 16'h1230, 2'd0, 2'd0, 2'd0, 11'h010, 16'h1230},  // R4 clears bits only
    '{2'd1, 11'h010, 16'h1235, 2'd0, 2'd0, 2'd2, 11'h010, 16'h1230},  // R5 needs a bit set
    '{2'd1, 11'h020, 16'h00C3, 2'd0, 2'd0, 2'd0, 11'h020, 16'h00C3},  // R4 bit7 = 1
    '{2'd1, 11'h420, 16'h0F0F, 2'd0, 2'd0, 2'd0, 11'h420, 16'h0F0F},  // R4 bit7 = 0
    '{2'd2, 11'h000, 16'h0000, 2'd0, 2'd3, 2'd0, 11'h420, 16'hFFFF},  // R7 span 0..3
    '{2'd3, 11'h000, 16'h0000, 2'd0, 2'd0, 2'd0, 11'h205, 16'h5A5A},  // R8 R12 locked kept
    '{2'd1, 11'h010, 16'h1235, 2'd0, 2'd0, 2'd0, 11'h010, 16'h1235},  // R4 after erase
    '{2'd2, 11'h000, 16'h0000, 2'd2, 2'd2, 2'd0, 11'h010, 16'h1235}   // R7 span bounds
  };

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R14 act=%0h exp=%0h", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [1:0] st;
    int nw, nr, nf;
    for (int i = 0; i < 2048; i++) mem[i] = 16'hFFFF;
    mem[11'h205] = 16'h5A5A;
    mem[11'h601] = 16'h1111;

    repeat (4) @(negedge clk);
    // R1 during reset
    chk(req_ready && !done && !fl_we && !fl_re && status == 2'd0, "R1 in reset",
        {req_ready, done, fl_we, fl_re}, 4'b1000);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !done && !fl_we && !fl_re && status == 2'd0, "R1 after reset",
        {req_ready, done, fl_we, fl_re}, 4'b1000);

    // R3 identify
    run(2'd0, '0, '0, '0, '0, st);
    chk(st == 2'd0, "R3 status", st, 0);
    chk(id_mfr == 16'h0001, "R3 mfr", id_mfr, 16'h0001);
    chk(id_dev == 16'h22F9, "R3 dev", id_dev, 16'h22F9);
    chk(prot_flags == 4'b1010, "R3 lock flags", prot_flags, 4'b1010);
    chk(md == 0, "R3 back to read", md, 0);

    // R14 pulse shape
    @(negedge clk);
    chk(!done && req_ready, "R14 done one cycle then ready", {done, req_ready}, 2'b01);

    for (int i = 0; i < 9; i++) begin
      nw = n_wr; er_n = 0;
      run(VEC[i].op, VEC[i].a, VEC[i].d, VEC[i].f, VEC[i].l, st);
      chk(st == VEC[i].st, $sformatf("R4 R5 R7 vec%0d status", i), st, VEC[i].st);
      chk(mem[VEC[i].ca] == VEC[i].cv, $sformatf("R4 R7 R8 vec%0d word", i), mem[VEC[i].ca], VEC[i].cv);
      if (VEC[i].st == 2'd2) chk(n_wr == nw, "R5 no write cycle", n_wr - nw, 0);
      if (i == 5) begin
        chk(skip_cnt == 3'd2, "R8 skip count", skip_cnt, 2);
        chk(mem[11'h601] == 16'h1111, "R8 locked sector 3 kept", mem[11'h601], 16'h1111);
        chk(er_n == 2 && er_log[0] == 0 && er_log[1] == 2, "R7 order 0 then 2",
            {er_n[7:0], er_log[0][7:0], er_log[1][7:0]}, 24'h020002);
        chk((f0_cyc - rd_cyc) >= SETTLE, "R9 settle gap", f0_cyc - rd_cyc, SETTLE);
      end
      if (i == 6) chk(n_wr == nw + 1, "R12 single write", n_wr - nw, 1);
      if (i == 8) chk(er_n == 1 && er_log[0] == 2, "R7 single sector", er_n, 1);
    end

    // R11 empty span
    nw = n_wr; nr = n_rd;
    run(2'd2, '0, '0, 2'd3, 2'd1, st);
    chk(st == 2'd0, "R11 status", st, 0);
    chk(n_wr == nw && n_rd == nr, "R11 no bus access", (n_wr - nw) + (n_rd - nr), 0);

    // R6 program timeout
    stuck = 1'b1;
    run(2'd1, 11'h030, 16'h0000, '0, '0, st);
    chk(st == 2'd1, "R6 program timeout", st, 1);
    stuck = 1'b0;
    nw = n_wr;
    run(2'd3, '0, '0, '0, '0, st);
    chk(st == 2'd0 && md == 0, "R12 reset clears busy", {st, md[1:0]}, 0);

    // R10 erase timeout stops span
    stuck = 1'b1; er_n = 0; nf = n_f0;
    run(2'd2, '0, '0, 2'd0, 2'd2, st);
    stuck = 1'b0;
    chk(st == 2'd1, "R10 erase timeout", st, 1);
    chk(er_n == 1, "R10 span abandoned", er_n, 1);
    chk(n_f0 == nf + 1 && md == 0, "R10 reset still written", n_f0 - nf, 1);
    chk((f0_cyc - rd_cyc) >= SETTLE, "R9 R10 settle gap", f0_cyc - rd_cyc, SETTLE);

    // R13 swapped lanes
    swp = 1'b1;
    run(2'd0, '0, '0, '0, '0, st);
    chk(id_mfr == 16'h0001 && id_dev == 16'h22F9, "R13 identify", {id_mfr, id_dev}, 32'h000122F9);
    chk(prot_flags == 4'b1010, "R13 lock flags", prot_flags, 4'b1010);
    run(2'd1, 11'h040, 16'h1280, '0, '0, st);
    chk(st == 2'd0 && mem[11'h040] == 16'h1280, "R13 program", mem[11'h040], 16'h1280);
    nw = n_wr;
    run(2'd1, 11'h040, 16'h1281, '0, '0, st);
    chk(st == 2'd2 && n_wr == nw, "R13 R5 not erased", st, 2);
    swp = 1'b0;

    chk(hs_bad == 0, "R2 strobe hold", hs_bad, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule